// File: doc/BRIEF.md
# Three-Channel Programmable Interval Counter

This block is a timer peripheral with three independent 16-bit down-counters behind an 8-bit processor port. A command byte written to the command address chooses a channel, the byte order used for loading and reading, the counting behaviour, and whether counting is binary or decimal (BCD). The count itself is then written one byte at a time through that channel's own address. The block follows a single system clock. Each channel advances only in cycles where its `tick` input is high, so a slow external counting clock is brought in as a one-cycle enable pulse. A `gate` input per channel can pause or restart the channel. Each channel has one output, `cnt_out`.

The main mode is the periodic rate generator. The output stays high and drops low for exactly one tick at the end of every period of N ticks, and the count reloads by itself. Any other mode code is handled as a one-shot terminal-count mode. The processor can read the live count of any channel at that channel's address.

Top module: `prog_interval_timer`

## Requirements
- R1: Bus address 0, 1 and 2 reach channels 0, 1 and 2, and address 3 is the command port. Command bits 7:6 name the target channel. A command whose bits 7:6 are 11 has no effect on any channel.
- R2: Command bits 5:4 set the byte order. 01 means low byte only, with the high byte taken as 0. 10 means high byte only, with the low byte taken as 0. 11 means low byte first, then high byte. A command with 00 in bits 5:4 has no effect on the channel. For example, command 34h with data bytes 40h then C0h loads C040h into channel 0.
- R3: A command write resets the channel's write and read byte pointers and stops the channel. The count then holds, with the output high in mode 2 and low in any other mode, until the last byte of a new count has been written.
- R4: The first tick after the last count byte loads the count. After that, each tick with gate high decreases the count by one. In cycles without a tick the count never changes.
- R5: Command bits 3:1 equal to 010 select the rate generator. With a loaded count N, the output is low exactly after ticks N, 2N, 3N and so on, counted from the loading tick, and high after every other tick. The count reloads to N on the tick after it reaches 1.
- R6: In the rate generator, gate low forces the output high by the next clock edge and holds the count. A rising edge of gate makes the next tick reload the full count.
- R7: Command bit 0 set selects decimal counting, in which each 4-bit digit counts 9 down to 0. A count of 0 acts as 65536 in binary, so the next value after 0000h is FFFFh, and as 10000 in decimal, so the next value after 0000h is 9999h.
- R8: Any mode code other than 010 acts as terminal-count mode. The output is low from the command write, the count decreases from the loading tick, and the output goes high on the tick where the count reaches 0 and stays high.
- R9: A read at a channel's address returns its current count. It returns the low byte in low-only order and the high byte in high-only order. In low-then-high order, reads alternate, starting with the low byte after a command. A read at address 3 returns 00h.
- R10: Each channel counts only on its own tick and gate, so activity on one channel leaves the others unchanged.
- R11: After reset every output is high, every count is 0000h, and no channel counts until it is programmed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_cs | input | 1 | Chip select, active high |
| bus_rd | input | 1 | Read strobe, one cycle per byte |
| bus_wr | input | 1 | Write strobe, one cycle per byte |
| bus_addr | input | 2 | Channel or command address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid while bus_cs and bus_rd are high |
| tick | input | 3 | Per-channel counting enable, one cycle per count |
| gate | input | 3 | Per-channel gate |
| cnt_out | output | 3 | Per-channel output |

## Verification
Wrong internal state in a channel shows up at `cnt_out` within one period: a misplaced reload moves the one-tick low pulse, and a bad decrement shifts every later pulse. Because the live count can be read at any time, a wrong byte pointer, decimal borrow or load value is visible on the very next read after the tick that caused it. The bench therefore checks the output and reads back the count after every tick across a sweep of small counts. This exposes off-by-one errors in the period and in the reload within the first or second period.

// File: rtl/pit_pkg.sv
package pit_pkg;
   typedef enum logic [1:0] {
      ACC_NONE = 2'b00,
      ACC_LO   = 2'b01,
      ACC_HI   = 2'b10,
      ACC_LOHI = 2'b11
   } acc_e;

   localparam logic [2:0] MODE_RATE = 3'd2;
   localparam logic [1:0] CMD_ADDR  = 2'd3;

   typedef struct packed {
      logic [1:0] sel;
      acc_e       acc;
      logic [2:0] mode;
      logic       bcd;
   } cmd_t;
endpackage

// File: rtl/pit_dec.sv
module pit_dec #(
   parameter int CNT_W = 16
) (
   input  logic [CNT_W-1:0] val,
   input  logic             bcd,
   output logic [CNT_W-1:0] nxt
);
   localparam int NDIG = CNT_W / 4;

   logic [NDIG:0]      borrow;
   logic [CNT_W-1:0]   dec_bcd;
   logic [CNT_W-1:0]   dec_bin;

   assign borrow[0] = 1'b1;
   assign dec_bin   = val - 1'b1;

   for (genvar d = 0; d < NDIG; d++) begin : g_dig
      logic [3:0] nib;
      assign nib = val[4*d +: 4];
      assign dec_bcd[4*d +: 4] = !borrow[d] ? nib :
                                 (nib == 4'd0) ? 4'd9 : nib - 4'd1;
      assign borrow[d+1] = borrow[d] & (nib == 4'd0);
   end

   assign nxt = bcd ? dec_bcd : dec_bin;
endmodule

// File: rtl/pit_bus_if.sv
module pit_bus_if
   import pit_pkg::*;
#(
   parameter int NUM_CNT = 3,
   parameter int DATA_W  = 8
) (
   input  logic              bus_cs,
   input  logic              bus_rd,
   input  logic              bus_wr,
   input  logic [1:0]        bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [NUM_CNT-1:0] cmd_we,
   output logic [NUM_CNT-1:0] data_we,
   output logic [NUM_CNT-1:0] rd_stb
);
   cmd_t cmd;
   assign cmd = cmd_t'(bus_wdata[7:0]);

   for (genvar i = 0; i < NUM_CNT; i++) begin : g_ch
      assign cmd_we[i]  = bus_cs && bus_wr && (bus_addr == CMD_ADDR) &&
                          (cmd.sel == 2'(i)) && (cmd.acc != ACC_NONE);
      assign data_we[i] = bus_cs && bus_wr && (bus_addr == 2'(i));
      assign rd_stb[i]  = bus_cs && bus_rd && (bus_addr == 2'(i));
   end
endmodule

// File: rtl/pit_counter.sv
module pit_counter
   import pit_pkg::*;
#(
   parameter int CNT_W  = 16,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_we,
   input  logic              data_we,
   input  logic              rd_stb,
   input  logic [DATA_W-1:0] wdata,
   input  logic              tick,
   input  logic              gate,
   output logic [DATA_W-1:0] rd_byte,
   output logic              out,
   output logic [CNT_W-1:0]  cnt_o,
   output logic              armed_o,
   output logic              pend_o,
   output logic              rate_o
);
   cmd_t               cmd;
   acc_e               acc_q;
   logic [2:0]         mode_q;
   logic               bcd_q;
   logic               wr_hi_q, rd_hi_q;
   logic [DATA_W-1:0]  lsb_q;
   logic [CNT_W-1:0]   init_q, cnt_q, cnt_dec;
   logic               pend_q, armed_q, out_q, gate_q;
   logic               is_rate;

   assign cmd     = cmd_t'(wdata[7:0]);
   assign is_rate = (mode_q == MODE_RATE);

   pit_dec #(.CNT_W(CNT_W)) i_dec (
      .val (cnt_q),
      .bcd (bcd_q),
      .nxt (cnt_dec)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q   <= ACC_LOHI;
         mode_q  <= MODE_RATE;
         bcd_q   <= 1'b0;
         wr_hi_q <= 1'b0;
         rd_hi_q <= 1'b0;
         lsb_q   <= '0;
         init_q  <= '0;
         cnt_q   <= '0;
         pend_q  <= 1'b0;
         armed_q <= 1'b0;
         out_q   <= 1'b1;
         gate_q  <= 1'b0;
      end else begin
         gate_q <= gate;
         if (cmd_we) begin
            acc_q   <= cmd.acc;
            mode_q  <= cmd.mode;
            bcd_q   <= cmd.bcd;
            wr_hi_q <= 1'b0;
            rd_hi_q <= 1'b0;
            pend_q  <= 1'b0;
            armed_q <= 1'b0;
            out_q   <= (cmd.mode == MODE_RATE);
         end else begin
            if (tick) begin
               if (pend_q) begin
                  cnt_q   <= init_q;
                  pend_q  <= 1'b0;
                  armed_q <= 1'b1;
                  out_q   <= is_rate;
               end else if (armed_q && gate) begin
                  if (is_rate) begin
                     if (cnt_q == CNT_W'(1)) begin
                        cnt_q <= init_q;
                        out_q <= 1'b1;
                     end else begin
                        cnt_q <= cnt_dec;
                        out_q <= (cnt_q != CNT_W'(2));
                     end
                  end else begin
                     cnt_q <= cnt_dec;
                     if (cnt_q == CNT_W'(1)) out_q <= 1'b1;
                  end
               end
            end
            if (data_we) begin
               unique case (acc_q)
                  ACC_LO: begin
                     init_q <= {{(CNT_W-DATA_W){1'b0}}, wdata};
                     pend_q <= 1'b1;
                  end
                  ACC_HI: begin
                     init_q <= {wdata, {DATA_W{1'b0}}};
                     pend_q <= 1'b1;
                  end
                  ACC_LOHI: begin
                     if (!wr_hi_q) begin
                        lsb_q   <= wdata;
                        wr_hi_q <= 1'b1;
                     end else begin
                        init_q  <= {wdata, lsb_q};
                        pend_q  <= 1'b1;
                        wr_hi_q <= 1'b0;
                     end
                  end
                  default: ;
               endcase
            end
            if (rd_stb && acc_q == ACC_LOHI) rd_hi_q <= !rd_hi_q;
            if (is_rate && armed_q && gate && !gate_q) pend_q <= 1'b1;
            if (is_rate && !gate) out_q <= 1'b1;
         end
      end
   end

   always_comb begin
      unique case (acc_q)
         ACC_HI:   rd_byte = cnt_q[CNT_W-1 -: DATA_W];
         ACC_LOHI: rd_byte = rd_hi_q ? cnt_q[CNT_W-1 -: DATA_W] : cnt_q[DATA_W-1:0];
         default:  rd_byte = cnt_q[DATA_W-1:0];
      endcase
   end

   assign out     = out_q;
   assign cnt_o   = cnt_q;
   assign armed_o = armed_q;
   assign pend_o  = pend_q;
   assign rate_o  = is_rate;
endmodule

// File: rtl/prog_interval_timer.sv
module prog_interval_timer
   import pit_pkg::*;
#(
   parameter int NUM_CNT = 3,
   parameter int DATA_W  = 8,
   parameter int CNT_W   = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               bus_cs,
   input  logic               bus_rd,
   input  logic               bus_wr,
   input  logic [1:0]         bus_addr,
   input  logic [DATA_W-1:0]  bus_wdata,
   output logic [DATA_W-1:0]  bus_rdata,
   input  logic [NUM_CNT-1:0] tick,
   input  logic [NUM_CNT-1:0] gate,
   output logic [NUM_CNT-1:0] cnt_out
);
   localparam int FLAT_W = NUM_CNT * CNT_W;

   if (DATA_W != 8) begin : g_bad_data
      $error("command encoding needs an 8-bit port");
   end
   if (CNT_W != 2 * DATA_W) begin : g_bad_cnt
      $error("count must be exactly two port bytes wide");
   end
   if (NUM_CNT < 1 || NUM_CNT > 3) begin : g_bad_num
      $error("two address bits leave room for one to three channels");
   end

   logic [NUM_CNT-1:0] cmd_we, data_we, rd_stb;
   logic [NUM_CNT-1:0] ch_armed, ch_pend, ch_rate;
   logic [FLAT_W-1:0]  ch_cnt;
   logic [DATA_W-1:0]  ch_byte [NUM_CNT];

   pit_bus_if #(.NUM_CNT(NUM_CNT), .DATA_W(DATA_W)) i_bus (
      .bus_cs    (bus_cs),
      .bus_rd    (bus_rd),
      .bus_wr    (bus_wr),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .cmd_we    (cmd_we),
      .data_we   (data_we),
      .rd_stb    (rd_stb)
   );

   for (genvar i = 0; i < NUM_CNT; i++) begin : g_ch
      pit_counter #(.CNT_W(CNT_W), .DATA_W(DATA_W)) i_cnt (
         .clk     (clk),
         .rst_n   (rst_n),
         .cmd_we  (cmd_we[i]),
         .data_we (data_we[i]),
         .rd_stb  (rd_stb[i]),
         .wdata   (bus_wdata),
         .tick    (tick[i]),
         .gate    (gate[i]),
         .rd_byte (ch_byte[i]),
         .out     (cnt_out[i]),
         .cnt_o   (ch_cnt[i*CNT_W +: CNT_W]),
         .armed_o (ch_armed[i]),
         .pend_o  (ch_pend[i]),
         .rate_o  (ch_rate[i])
      );
   end

   always_comb begin
      bus_rdata = '0;
      for (int i = 0; i < NUM_CNT; i++) begin
         if (rd_stb[i]) bus_rdata = ch_byte[i];
      end
   end
endmodule

// File: rtl/pit_checker.sv
module pit_checker #(
   parameter int NUM_CNT = 3,
   parameter int DATA_W  = 8,
   parameter int CNT_W   = 16
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic                       bus_cs,
   input logic                       bus_rd,
   input logic [1:0]                 bus_addr,
   input logic [DATA_W-1:0]          bus_rdata,
   input logic [NUM_CNT-1:0]         tick,
   input logic [NUM_CNT-1:0]         gate,
   input logic [NUM_CNT-1:0]         cnt_out,
   input logic [NUM_CNT-1:0]         cmd_we,
   input logic [NUM_CNT-1:0]         ch_armed,
   input logic [NUM_CNT-1:0]         ch_pend,
   input logic [NUM_CNT-1:0]         ch_rate,
   input logic [NUM_CNT*CNT_W-1:0]   ch_cnt
);
   p_cmd_read_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_cs && bus_rd && bus_addr == 2'd3) |-> (bus_rdata == '0));

   for (genvar i = 0; i < NUM_CNT; i++) begin : g_ch
      p_gate_forces_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
         (ch_rate[i] && !gate[i] && !cmd_we[i]) |=> cnt_out[i]);

      p_gate_holds_count_r6: assert property (@(posedge clk) disable iff (!rst_n)
         (ch_armed[i] && !gate[i] && !ch_pend[i]) |=> $stable(ch_cnt[i*CNT_W +: CNT_W]));

      p_low_one_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
         (ch_rate[i] && ch_armed[i] && !ch_pend[i] && !cnt_out[i] && tick[i] &&
          gate[i] && !cmd_we[i]) |=> cnt_out[i]);

      p_idle_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
         (!ch_armed[i] && !ch_pend[i]) |=> $stable(ch_cnt[i*CNT_W +: CNT_W]));

      p_no_tick_no_change_r4: assert property (@(posedge clk) disable iff (!rst_n)
         !tick[i] |=> $stable(ch_cnt[i*CNT_W +: CNT_W]));
   end
endmodule

bind prog_interval_timer pit_checker #(
   .NUM_CNT (NUM_CNT),
   .DATA_W  (DATA_W),
   .CNT_W   (CNT_W)
) i_pit_checker (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_cs    (bus_cs),
   .bus_rd    (bus_rd),
   .bus_addr  (bus_addr),
   .bus_rdata (bus_rdata),
   .tick      (tick),
   .gate      (gate),
   .cnt_out   (cnt_out),
   .cmd_we    (cmd_we),
   .ch_armed  (ch_armed),
   .ch_pend   (ch_pend),
   .ch_rate   (ch_rate),
   .ch_cnt    (ch_cnt)
);

// File: tb/test_prog_interval_timer.sv
module test_prog_interval_timer;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_cs = 1'b0, bus_rd = 1'b0, bus_wr = 1'b0;
   logic [1:0] bus_addr = '0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic [2:0] tick = '0;
   logic [2:0] gate = 3'b111;
   logic [2:0] cnt_out;

   int n_run = 0;
   int n_fail = 0;

   always #4 clk = !clk;

   prog_interval_timer i_prog_interval_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_cs    (bus_cs),
      .bus_rd    (bus_rd),
      .bus_wr    (bus_wr),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .tick      (tick),
      .gate      (gate),
      .cnt_out   (cnt_out)
   );

   task automatic check(input string tag, input int got, input int exp);
      n_run++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %0h expected %0h", tag, got, exp);
      end
   endtask

   task automatic wr_bus(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_cs = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_cs = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic rd_bus(input logic [1:0] a, output logic [7:0] d);
      @(negedge clk);
      bus_cs = 1'b1; bus_rd = 1'b1; bus_addr = a;
      #2 d = bus_rdata;
      @(negedge clk);
      bus_cs = 1'b0; bus_rd = 1'b0;
   endtask

   task automatic rd_cnt(input logic [1:0] a, output int v);
      logic [7:0] lo, hi;
      rd_bus(a, lo);
      rd_bus(a, hi);
      v = {hi, lo};
   endtask

   task automatic tk(input logic [2:0] m);
      @(negedge clk);
      tick = m;
      @(negedge clk);
      tick = '0;
   endtask

   task automatic idle();
      @(negedge clk);
   endtask

   task automatic load(input logic [1:0] ch, input logic [7:0] cmd, input int n);
      wr_bus(2'd3, cmd);
      wr_bus(ch, n[7:0]);
      wr_bus(ch, n[15:8]);
   endtask

   function automatic int to_bcd(input int v);
      return ((v / 1000) % 10) * 4096 + ((v / 100) % 10) * 256 +
             ((v / 10) % 10) * 16 + (v % 10);
   endfunction

   initial begin
      #(8 * 150000);
      n_fail++;
      $display("FAIL watchdog: run did not finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      int v;
      logic [7:0] b;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      idle();

      // R11 reset state
      check("R11 outputs high", cnt_out, 3'b111);
      rd_cnt(2'd0, v); check("R11 count zero", v, 0);
      // R9 command address reads zero
      rd_bus(2'd3, b); check("R9 cmd read", b, 0);

      // R5 R4 R2 rate generator sweep
      for (int n = 2; n <= 7; n++) begin
         load(2'd0, 8'h34, n);
         check("R3 high before load", cnt_out[0], 1);
         for (int t = 1; t <= 2 * n + 1; t++) begin
            tk(3'b001);
            check("R5 out", cnt_out[0], (t % n) != 0);
            rd_cnt(2'd0, v);
            check("R4 count", v, n - ((t - 1) % n));
         end
      end

      // R2 full example load C040h
      load(2'd0, 8'h34, 16'hC040);
      tk(3'b001);
      rd_cnt(2'd0, v); check("R2 lo-hi load", v, 16'hC040);

      // R7 binary zero
      load(2'd0, 8'h34, 0);
      tk(3'b001); rd_cnt(2'd0, v); check("R7 bin zero", v, 0);
      tk(3'b001); rd_cnt(2'd0, v); check("R7 bin wrap", v, 16'hFFFF);

      // R7 decimal period 12
      load(2'd0, 8'h35, 16'h0012);
      for (int t = 1; t <= 25; t++) begin
         tk(3'b001);
         check("R7 bcd out", cnt_out[0], (t % 12) != 0);
         rd_cnt(2'd0, v);
         check("R7 bcd count", v, to_bcd(12 - ((t - 1) % 12)));
      end
      load(2'd0, 8'h35, 0);
      tk(3'b001); tk(3'b001);
      rd_cnt(2'd0, v); check("R7 bcd wrap", v, 16'h9999);

      // R2 low only
      wr_bus(2'd3, 8'h14); wr_bus(2'd0, 8'h07);
      tk(3'b001);
      rd_bus(2'd0, b); check("R2 lo read", b, 8'h07);
      rd_bus(2'd0, b); check("R2 lo read again", b, 8'h07);
      for (int t = 2; t <= 7; t++) begin
         tk(3'b001);
         check("R2 lo period", cnt_out[0], (t % 7) != 0);
      end
      // R2 high only
      wr_bus(2'd3, 8'h24); wr_bus(2'd0, 8'h02);
      tk(3'b001);
      rd_bus(2'd0, b); check("R2 hi read", b, 8'h02);
      tk(3'b001);
      rd_bus(2'd0, b); check("R2 hi read after dec", b, 8'h01);

      // R2 R1 ignored commands
      load(2'd0, 8'h34, 5);
      tk(3'b001); tk(3'b001);
      wr_bus(2'd3, 8'h04);
      tk(3'b001); rd_cnt(2'd0, v); check("R2 acc 00 ignored", v, 3);
      wr_bus(2'd3, 8'hF4);
      tk(3'b001); rd_cnt(2'd0, v); check("R1 sel 11 ignored", v, 2);
      tk(3'b001); check("R1 still running", cnt_out[0], 0);

      // R3 command halts until full count
      wr_bus(2'd3, 8'h34);
      check("R3 out high after cmd", cnt_out[0], 1);
      tk(3'b001); tk(3'b001);
      rd_cnt(2'd0, v); check("R3 held", v, 1);
      wr_bus(2'd0, 8'h09);
      tk(3'b001);
      rd_cnt(2'd0, v); check("R3 held half load", v, 1);
      wr_bus(2'd0, 8'h00);
      tk(3'b001);
      rd_cnt(2'd0, v); check("R3 new count", v, 9);

      // R6 gate
      load(2'd0, 8'h34, 3);
      tk(3'b001); tk(3'b001); tk(3'b001);
      check("R6 low before gate", cnt_out[0], 0);
      gate[0] = 1'b0;
      idle();
      check("R6 gate forces high", cnt_out[0], 1);
      tk(3'b001); tk(3'b001);
      rd_cnt(2'd0, v); check("R6 gate holds", v, 1);
      gate[0] = 1'b1;
      idle();
      tk(3'b001);
      rd_cnt(2'd0, v); check("R6 rise reloads", v, 3);
      tk(3'b001); tk(3'b001);
      check("R6 period after reload", cnt_out[0], 0);

      // R8 terminal count mode
      load(2'd0, 8'h30, 4);
      check("R8 low after cmd", cnt_out[0], 0);
      for (int t = 1; t <= 6; t++) begin
         tk(3'b001);
         check("R8 out", cnt_out[0], t >= 5);
         rd_cnt(2'd0, v);
         check("R8 count", v, (4 - (t - 1)) & 16'hFFFF);
      end

      // R10 independent channels
      load(2'd1, 8'h74, 3);
      load(2'd2, 8'hB4, 5);
      for (int t = 1; t <= 15; t++) begin
         tk(3'b110);
         check("R10 ch1 out", cnt_out[1], (t % 3) != 0);
         check("R10 ch2 out", cnt_out[2], (t % 5) != 0);
      end
      rd_cnt(2'd1, v); check("R10 ch1 count", v, 1);
      tk(3'b100); tk(3'b100);
      rd_cnt(2'd1, v); check("R10 ch1 untouched", v, 1);
      rd_cnt(2'd2, v); check("R10 ch2 moved", v, 4);
      rd_cnt(2'd0, v); check("R10 ch0 untouched", v, 16'hFFFF);

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule